// File: doc/BRIEF.md
# Interlaced 4:2:2 Digital Video Stream Generator

This block produces a byte-wide component video stream for a 525-line interlaced system. It emits one word on every cycle of a 27 MHz clock. Synchronisation is not carried on separate wires. Each line opens with an end-of-active timing code, continues with a horizontal blanking fill, then a start-of-active timing code, and finishes with the active picture words. The picture words are chroma and luma interleaved as Cb, Y, Cr, Y, so each chroma pair is shared by two luma samples.

Two counters track the position: a word counter within the line and a line counter within the frame. The line number sets the field flag and the vertical blanking flag. On active lines the block asks an external pixel source for each pixel pair one cycle before that pair's Cb word goes out. The source answers in that same cycle with two luma bytes and one chroma pair. If the source cannot answer, the block fills the pair with blanking values and records the miss in a sticky flag.

The line and frame geometry are parameters. The defaults are 720 active pixels, 268 horizontal blanking words and 525 lines, which gives 1716 words per line. Ports: `clk`, `rst`, `pix_req`, `pix_valid`, `pix_cb`, `pix_y0`, `pix_cr`, `pix_y1`, `vid_data`, `underrun`.

Top module: `vid656_gen`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the outputs go to `vid_data` = 0x80, `underrun` = 0 and `pix_req` = 0. The first word after reset is released is word 0 of line 1.
- R2: A line has 8 + HBLANK_WORDS + 2·ACT_PIX words, which is 1716 with the defaults. The end-of-active code takes words 0–3. The start-of-active code takes words 4+HBLANK_WORDS to 7+HBLANK_WORDS, which is 272–275 with the defaults. Active words follow the start-of-active code.
- R3: Every timing code is the four words 0xFF, 0x00, 0x00, XY. No other word of the stream is ever 0xFF or 0x00.
- R4: The bit layout of XY is as follows:
  - bit 7 is 1;
  - bit 6 is F;
  - bit 5 is V;
  - bit 4 is H, which is 1 in the end-of-active code and 0 in the start-of-active code;
  - bits 3, 2, 1 and 0 are V^H, F^H, F^V and F^V^H.
  
  F is 0 on lines F0_FIRST..F0_LAST (4..265 with the defaults) and 1 on all other lines.
- R5: V is 1 on lines 1..VB1_LAST and on lines VB2_FIRST..VB2_LAST. With the defaults these are 1–19 and 264–282, which leaves 487 active lines per frame.
- R6: Any word that is neither a code word nor active picture is a fill word. A fill word is 0x80 at an even word index and 0x10 at an odd word index. On lines with V=1, every word outside the codes is a fill word.
- R7: On a line with V=0, each pixel pair is sent as Cb, Y0, Cr, Y1, starting at the first active word. An input byte of 0x00 is sent as 0x01, and an input byte of 0xFF is sent as 0xFE.
- R8: `pix_req` is high for exactly one cycle, the cycle before each Cb word of a line with V=0. It is never high on lines with V=1. The pair is accepted only if `pix_valid` is high in that same cycle.
- R9: When `pix_req` is high and `pix_valid` is low, that pair is sent as 0x80, 0x10, 0x80, 0x10. In that case `underrun` rises on the Cb word and stays high until reset.
- R10: After line FRAME_LINES the line counter returns to line 1. The end-of-active XY of that line is 0xF1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (27 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| pix_req | output | 1 | Pixel pair request, one cycle before the Cb word |
| pix_valid | input | 1 | Source answers the request in the same cycle |
| pix_cb | input | 8 | Blue-difference chroma of the pair |
| pix_y0 | input | 8 | Luma of the first pixel |
| pix_cr | input | 8 | Red-difference chroma of the pair |
| pix_y1 | input | 8 | Luma of the second pixel |
| vid_data | output | 8 | Multiplexed video word stream |
| underrun | output | 1 | Sticky flag: a requested pair was missing |

## Verification
The hardest cases to reach from the ports are the frame-level events. These are the field and vertical-blanking changes at specific line numbers, and the wrap from the last line back to line 1. With the default geometry, a full frame takes close to a million cycles. For that reason, the main bench instance uses a reduced geometry of 24-word lines and a 25-line frame. That geometry keeps every field and vertical-blanking boundary and wraps the frame several times. Under seeded random source behaviour, it checks each word against a bench model, including random missed requests and forced 0x00/0xFF pixel bytes. A second instance with the default geometry checks the code positions and the line length of 1716 words during the first two lines.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

  typedef enum logic [1:0] {
    SLOT_CB = 2'd0,
    SLOT_Y0 = 2'd1,
    SLOT_CR = 2'd2,
    SLOT_Y1 = 2'd3
  } slot_t;

  localparam logic [7:0] FILL_CHROMA = 8'h80;
  localparam logic [7:0] FILL_LUMA   = 8'h10;

  // Status word of a timing code, protection bits included.
  function automatic logic [7:0] xy_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // Word at position pos (0..3) inside a timing code.
  function automatic logic [7:0] code_word(input logic [1:0] pos, input logic f,
                                           input logic v, input logic h);
    case (pos)
      2'd0:    return 8'hFF;
      2'd3:    return xy_word(f, v, h);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fill_word(input logic odd);
    return odd ? FILL_LUMA : FILL_CHROMA;
  endfunction

  // Keep picture data out of the reserved code values.
  function automatic logic [7:0] clip8(input logic [7:0] x);
    if (x == 8'h00) return 8'h01;
    if (x == 8'hFF) return 8'hFE;
    return x;
  endfunction

endpackage

// File: rtl/vid656_timing.sv
module vid656_timing #(
  parameter int LINE_WORDS  = 1716,
  parameter int FRAME_LINES = 525,
  parameter int F0_FIRST    = 4,
  parameter int F0_LAST     = 265,
  parameter int VB1_LAST    = 19,
  parameter int VB2_FIRST   = 264,
  parameter int VB2_LAST    = 282,
  parameter int HW          = 11,
  parameter int LW          = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_cnt,
  output logic [LW-1:0] line_no,
  output logic          fld,
  output logic          vbl,
  output logic          line_end,
  output logic          frame_end
);

  localparam logic [HW-1:0] H_LAST = HW'(LINE_WORDS - 1);
  localparam logic [LW-1:0] L_LAST = LW'(FRAME_LINES);

  assign line_end  = (h_cnt == H_LAST);
  assign frame_end = line_end && (line_no == L_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt   <= '0;
      line_no <= LW'(1);
    end else if (line_end) begin
      h_cnt   <= '0;
      line_no <= frame_end ? LW'(1) : line_no + LW'(1);
    end else begin
      h_cnt <= h_cnt + HW'(1);
    end
  end

  assign fld = !((line_no >= LW'(F0_FIRST)) && (line_no <= LW'(F0_LAST)));
  assign vbl = (line_no <= LW'(VB1_LAST)) ||
               ((line_no >= LW'(VB2_FIRST)) && (line_no <= LW'(VB2_LAST)));

endmodule

// File: rtl/vid656_fetch.sv
module vid656_fetch (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       pix_valid,
  input  logic [7:0] pix_y0,
  input  logic [7:0] pix_cr,
  input  logic [7:0] pix_y1,
  output logic       take,
  output logic       miss,
  output logic       hit,
  output logic [7:0] y0_q,
  output logic [7:0] cr_q,
  output logic [7:0] y1_q,
  output logic       underrun
);

  assign take = req && pix_valid;
  assign miss = req && !pix_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit      <= 1'b0;
      underrun <= 1'b0;
      y0_q     <= '0;
      cr_q     <= '0;
      y1_q     <= '0;
    end else if (req) begin
      hit <= pix_valid;
      if (pix_valid) begin
        y0_q <= pix_y0;
        cr_q <= pix_cr;
        y1_q <= pix_y1;
      end else begin
        underrun <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vid656_mux.sv
module vid656_mux
  import vid656_pkg::*;
#(
  parameter int HW        = 11,
  parameter int SAV_START = 272,
  parameter int ACT_START = 276
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_cnt,
  input  logic          fld,
  input  logic          vbl,
  input  logic          take,
  input  logic          hit,
  input  logic [7:0]    pix_cb,
  input  logic [7:0]    y0_q,
  input  logic [7:0]    cr_q,
  input  logic [7:0]    y1_q,
  output logic          cb_next,
  output logic [7:0]    vid_data
);

  localparam logic [HW-1:0] SAV_H = HW'(SAV_START);
  localparam logic [HW-1:0] ACT_H = HW'(ACT_START);

  logic       in_eav, in_sav, in_act;
  logic [1:0] cpos;
  slot_t      slot;
  logic [7:0] nxt;

  always_comb begin
    in_eav  = (h_cnt < HW'(4));
    in_sav  = (h_cnt >= SAV_H) && (h_cnt < ACT_H);
    in_act  = (h_cnt >= ACT_H);
    cpos    = in_eav ? h_cnt[1:0] : (h_cnt[1:0] - SAV_H[1:0]);
    slot    = slot_t'(h_cnt[1:0] - ACT_H[1:0]);
    cb_next = in_act && (slot == SLOT_CB);
    if (in_eav || in_sav) begin
      nxt = code_word(cpos, fld, vbl, in_eav);
    end else if (in_act && !vbl) begin
      case (slot)
        SLOT_CB: nxt = take ? clip8(pix_cb) : FILL_CHROMA;
        SLOT_Y0: nxt = hit  ? clip8(y0_q)   : FILL_LUMA;
        SLOT_CR: nxt = hit  ? clip8(cr_q)   : FILL_CHROMA;
        default: nxt = hit  ? clip8(y1_q)   : FILL_LUMA;
      endcase
    end else begin
      nxt = fill_word(h_cnt[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vid_data <= FILL_CHROMA;
    else     vid_data <= nxt;
  end

endmodule

// File: rtl/vid656_gen.sv
module vid656_gen #(
  parameter int ACT_PIX      = 720,
  parameter int HBLANK_WORDS = 268,
  parameter int FRAME_LINES  = 525,
  parameter int F0_FIRST     = 4,
  parameter int F0_LAST      = 265,
  parameter int VB1_LAST     = 19,
  parameter int VB2_FIRST    = 264,
  parameter int VB2_LAST     = 282
) (
  input  logic       clk,
  input  logic       rst,
  output logic       pix_req,
  input  logic       pix_valid,
  input  logic [7:0] pix_cb,
  input  logic [7:0] pix_y0,
  input  logic [7:0] pix_cr,
  input  logic [7:0] pix_y1,
  output logic [7:0] vid_data,
  output logic       underrun
);

  localparam int CODE_WORDS = 4;
  localparam int ACT_WORDS  = 2 * ACT_PIX;
  localparam int SAV_START  = CODE_WORDS + HBLANK_WORDS;
  localparam int ACT_START  = SAV_START + CODE_WORDS;
  localparam int LINE_WORDS = ACT_START + ACT_WORDS;
  localparam int HW         = $clog2(LINE_WORDS);
  localparam int LW         = $clog2(FRAME_LINES + 1);

  logic [HW-1:0] h_cnt;
  logic [LW-1:0] line_no;
  logic          fld, vbl;
  logic          evt_line_end, evt_frame_end;
  logic          evt_req, evt_take, evt_miss, cb_next, hit;
  logic [7:0]    y0_q, cr_q, y1_q;

  vid656_timing #(
    .LINE_WORDS(LINE_WORDS), .FRAME_LINES(FRAME_LINES),
    .F0_FIRST(F0_FIRST), .F0_LAST(F0_LAST),
    .VB1_LAST(VB1_LAST), .VB2_FIRST(VB2_FIRST), .VB2_LAST(VB2_LAST),
    .HW(HW), .LW(LW)
  ) u_timing (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .line_no(line_no),
    .fld(fld), .vbl(vbl), .line_end(evt_line_end), .frame_end(evt_frame_end)
  );

  assign evt_req = !rst && !vbl && cb_next;
  assign pix_req = evt_req;

  vid656_fetch u_fetch (
    .clk(clk), .rst(rst), .req(evt_req), .pix_valid(pix_valid),
    .pix_y0(pix_y0), .pix_cr(pix_cr), .pix_y1(pix_y1),
    .take(evt_take), .miss(evt_miss), .hit(hit),
    .y0_q(y0_q), .cr_q(cr_q), .y1_q(y1_q), .underrun(underrun)
  );

  vid656_mux #(
    .HW(HW), .SAV_START(SAV_START), .ACT_START(ACT_START)
  ) u_mux (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .fld(fld), .vbl(vbl),
    .take(evt_take), .hit(hit), .pix_cb(pix_cb),
    .y0_q(y0_q), .cr_q(cr_q), .y1_q(y1_q),
    .cb_next(cb_next), .vid_data(vid_data)
  );

endmodule

// File: rtl/vid656_chk.sv
module vid656_chk #(
  parameter int HW          = 11,
  parameter int LW          = 10,
  parameter int LINE_WORDS  = 1716,
  parameter int FRAME_LINES = 525
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_req,
  input logic          pix_valid,
  input logic [7:0]    pix_cb,
  input logic [7:0]    vid_data,
  input logic          underrun,
  input logic [HW-1:0] h_cnt,
  input logic [LW-1:0] line_no,
  input logic          vbl,
  input logic          evt_line_end,
  input logic          evt_frame_end,
  input logic          evt_miss
);

  AST_CTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    {1'b0, h_cnt} < (HW+1)'(LINE_WORDS)); // R2
  AST_LINE_LEN: assert property (@(posedge clk) disable iff (rst)
    evt_line_end |=> (h_cnt == '0)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    evt_frame_end |=> (line_no == LW'(1))); // R10
  AST_LINE_MAX: assert property (@(posedge clk) disable iff (rst)
    evt_line_end && !evt_frame_end |=> (line_no <= LW'(FRAME_LINES))); // R10
  AST_CODE_SEQ: assert property (@(posedge clk) disable iff (rst)
    (vid_data == 8'hFF) |=> (vid_data == 8'h00)); // R3
  AST_XY_PROT: assert property (@(posedge clk) disable iff (rst)
    ($past(vid_data, 3) == 8'hFF && $past(vid_data, 2) == 8'h00 && $past(vid_data) == 8'h00)
    |-> (vid_data[7] && vid_data[3] == (vid_data[5] ^ vid_data[4]) &&
         vid_data[2] == (vid_data[6] ^ vid_data[4]) &&
         vid_data[1] == (vid_data[6] ^ vid_data[5]) &&
         vid_data[0] == (vid_data[6] ^ vid_data[5] ^ vid_data[4]))); // R4
  AST_REQ_VBL: assert property (@(posedge clk) disable iff (rst)
    pix_req |-> !vbl); // R8
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pix_req |=> !pix_req); // R8
  AST_CB_PASS: assert property (@(posedge clk) disable iff (rst)
    (pix_req && pix_valid && pix_cb != 8'h00 && pix_cb != 8'hFF) |=> (vid_data == $past(pix_cb))); // R7
  AST_MISS_FILL: assert property (@(posedge clk) disable iff (rst)
    evt_miss |=> (vid_data == 8'h80 && underrun)); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun); // R9

endmodule

bind vid656_gen vid656_chk #(
  .HW(HW), .LW(LW), .LINE_WORDS(LINE_WORDS), .FRAME_LINES(FRAME_LINES)
) u_chk (
  .clk(clk), .rst(rst), .pix_req(pix_req), .pix_valid(pix_valid), .pix_cb(pix_cb),
  .vid_data(vid_data), .underrun(underrun), .h_cnt(h_cnt), .line_no(line_no),
  .vbl(vbl), .evt_line_end(evt_line_end), .evt_frame_end(evt_frame_end),
  .evt_miss(evt_miss)
);

// File: tb/test_vid656_gen.sv
module test_vid656_gen;
  localparam int CLK_PERIOD = 10;
  // Reduced geometry for the main instance
  localparam int AP = 4, HB = 8, FL = 25, F0A = 4, F0B = 13, V1 = 3, V2A = 12, V2B = 15;
  localparam int SAVS = 4 + HB, ACTS = SAVS + 4, LWD = ACTS + 2 * AP;

  logic clk = 0, rst = 1;
  logic pix_valid = 0;
  logic [7:0] pix_cb = 0, pix_y0 = 0, pix_cr = 0, pix_y1 = 0;
  logic pix_req, underrun;
  logic [7:0] vid_data;
  logic f_req, f_under;
  logic [7:0] f_data;

  int n_cmp = 0, n_bad = 0, mode = 0, fcyc = 0;
  bit started = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid656_gen #(.ACT_PIX(AP), .HBLANK_WORDS(HB), .FRAME_LINES(FL), .F0_FIRST(F0A),
               .F0_LAST(F0B), .VB1_LAST(V1), .VB2_FIRST(V2A), .VB2_LAST(V2B)) i_vid656_gen (
    .clk(clk), .rst(rst), .pix_req(pix_req), .pix_valid(pix_valid), .pix_cb(pix_cb),
    .pix_y0(pix_y0), .pix_cr(pix_cr), .pix_y1(pix_y1), .vid_data(vid_data), .underrun(underrun));

  vid656_gen i_vid656_gen_full (
    .clk(clk), .rst(rst), .pix_req(f_req), .pix_valid(1'b0), .pix_cb(8'h00),
    .pix_y0(8'h00), .pix_cr(8'h00), .pix_y1(8'h00), .vid_data(f_data), .underrun(f_under));

  function automatic logic [7:0] clipb(input logic [7:0] x);
    return (x == 8'h00) ? 8'h01 : ((x == 8'hFF) ? 8'hFE : x);
  endfunction
  function automatic logic m_vbl(input int l);
    return (l <= V1) || (l >= V2A && l <= V2B);
  endfunction
  function automatic logic m_fld(input int l);
    return (l < F0A) || (l > F0B);
  endfunction
  function automatic logic [7:0] m_xy(input logic f, input logic v, input logic h);
    logic [7:0] r;
    r = 8'h80 | (f ? 8'h40 : 8'h00) | (v ? 8'h20 : 8'h00) | (h ? 8'h10 : 8'h00);
    r[3] = (v != h); r[2] = (f != h); r[1] = (f != v); r[0] = ((f + v + h) % 2) == 1;
    return r;
  endfunction
  function automatic logic [7:0] rnd_byte();
    int r;
    r = $urandom % 16;
    if (r == 0) return 8'h00;
    if (r == 1) return 8'hFF;
    return 8'($urandom);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench model of the stream, advanced on each rising edge
  int mw = 0, ml = 1;
  bit mhit = 0, exp_under = 0;
  logic [7:0] exp_data = 8'h80, hy0, hcr, hy1;
  string exp_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      mw = 0; ml = 1; mhit = 0; exp_under = 0; exp_data = 8'h80; exp_tag = "R1";
    end else begin
      if (mw < 4 || (mw >= SAVS && mw < ACTS)) begin
        int p;
        p = (mw < 4) ? mw : mw - SAVS;
        exp_data = (p == 0) ? 8'hFF : (p == 3) ? m_xy(m_fld(ml), m_vbl(ml), mw < 4) : 8'h00;
        exp_tag = (p != 3) ? "R3" : ((ml == 1 && mw < 4) ? "R10" : "R4 R5");
      end else if (mw >= ACTS && !m_vbl(ml)) begin
        case ((mw - ACTS) % 4)
          0: if (pix_valid) begin
               mhit = 1; hy0 = pix_y0; hcr = pix_cr; hy1 = pix_y1;
               exp_data = clipb(pix_cb); exp_tag = "R7";
             end else begin
               mhit = 0; exp_under = 1; exp_data = 8'h80; exp_tag = "R9";
             end
          1: begin exp_data = mhit ? clipb(hy0) : 8'h10; exp_tag = mhit ? "R7" : "R9"; end
          2: begin exp_data = mhit ? clipb(hcr) : 8'h80; exp_tag = mhit ? "R7" : "R9"; end
          default: begin exp_data = mhit ? clipb(hy1) : 8'h10; exp_tag = mhit ? "R7" : "R9"; end
        endcase
      end else begin
        exp_data = (mw % 2 == 1) ? 8'h10 : 8'h80; exp_tag = "R6";
      end
      mw++;
      if (mw == LWD) begin mw = 0; ml = (ml == FL) ? 1 : ml + 1; end
    end
    fcyc = rst ? 0 : fcyc + 1;
  end

  // Compare away from the edge, then drive the next stimulus
  always @(negedge clk) begin
    if (started) begin
      logic exp_req;
      exp_req = !rst && !m_vbl(ml) && mw >= ACTS && ((mw - ACTS) % 4 == 0);
      chk(exp_tag, vid_data, exp_data);
      chk("R8 req", {7'd0, pix_req}, {7'd0, exp_req});
      chk("R9 underrun", {7'd0, underrun}, {7'd0, exp_under});
      case (fcyc)
        1:    chk("R2 full EAV", f_data, 8'hFF);
        4:    chk("R10 full XY line1", f_data, 8'hF1);
        5:    chk("R2 full fill even", f_data, 8'h80);
        273:  chk("R2 full SAV", f_data, 8'hFF);
        276:  chk("R4 full SAV XY", f_data, 8'hEC);
        1716: chk("R2 full last word", f_data, 8'h10);
        1717: chk("R2 full next EAV", f_data, 8'hFF);
        default: ;
      endcase
    end
    pix_valid = (mode == 0) ? 1'b1 : (($urandom % 10) < 8);
    pix_cb = rnd_byte(); pix_y0 = rnd_byte(); pix_cr = rnd_byte(); pix_y1 = rnd_byte();
  end

  initial begin
    void'($urandom(32'd656));
    repeat (3) @(posedge clk);
    started = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset data", vid_data, 8'h80);
    chk("R1 reset req", {7'd0, pix_req}, 8'd0);
    chk("R1 reset underrun", {7'd0, underrun}, 8'd0);
    rst = 0;
    @(negedge clk);
    chk("R1 first word EAV", vid_data, 8'hFF);
    repeat (2 * FL * LWD) @(negedge clk);
    mode = 1;
    repeat (3 * FL * LWD + 37) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 mid reset underrun", {7'd0, underrun}, 8'd0);
    rst = 0;
    repeat (FL * LWD) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule